// File: doc/BRIEF.md
# I2C Auto-Increment Port Register File

This block is an I2C target that gives a bus master access to a set of 8-bit general-purpose ports through a one-byte register address. Each port has two register slots: an input slot that returns the current level of the port's pins and an output slot that holds the value driven onto the port. A write transaction first loads a register pointer and then stores data bytes. A read transaction is a write of the pointer followed by a repeated START with the read bit set.

After every data byte the pointer advances by one, so a single burst sweeps across neighbouring ports. Each port is handled at the moment its own byte passes. An input slot samples the pins just before its byte starts to shift out. An output slot drives its port as soon as its byte has been received. The ports are not handled all together at the end of the transaction.

SCL and SDA are sampled by the system clock through a synchronizer. SDA is open-drain: the block only pulls it low, through `sda_oe`. The port count and the device address are parameters.

Top module: `i2cgp_top`

## Requirements
- R1: While reset is held and after it is released, every output register is zero, so `port_out` is all zeros, and `sda_oe` is 0.
- R2: The first byte after a START carries the 7-bit device address `DEV_ADDR` (default 7'h20), MSB first, followed by a direction bit (0 = write, 1 = read). On a match the target pulls SDA low during the ninth clock. On any other address it does not acknowledge, and it ignores the bus until the next START.
- R3: In a write, the byte after the address loads the 4-bit register pointer from its low four bits and ignores its upper four bits. Pointer value 0h+k selects the input slot of port k. Pointer value 8h+k selects the output slot of port k.
- R4: A byte written to the output slot of port k appears on `port_out[8k+7:8k]` after its eighth bit has been received and before its acknowledge clock ends. The other ports do not change.
- R5: The pointer advances by one after every data byte, whether read or written. It wraps from Fh to 0h.
- R6: A read of an input slot returns the pins as they stand at the SCL falling edge that begins that byte. That edge is the end of the preceding acknowledge clock. Pin changes before or after that edge do not affect the byte.
- R7: A read of an output slot returns the value last written to it.
- R8: A data byte written to an input slot is acknowledged and changes nothing.
- R9: Slots of ports numbered `NPORT` or above read as zero. Writes to them are acknowledged and ignored.
- R10: During a read, an acknowledge from the master (SDA low in the ninth clock) makes the target send the next byte. A not-acknowledge makes the target release SDA and keep it released until the next START.
- R11: A repeated START with the read bit set, after a pointer write, begins reading at the slot the pointer selects.
- R12: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, many times faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe | output | 1 | When 1, the target pulls SDA low |
| port_in | input | NPORT*8 | Pin levels of all ports, port k in bits 8k+7:8k |
| port_out | output | NPORT*8 | Output registers of all ports, port k in bits 8k+7:8k |

## Verification
The assertions watch properties that hold on every cycle. SDA drive may change only while SCL is low. The target never drives SDA while the bus is idle. A port output may change only in the cycle after a data write, and never after a write to an input slot or to a missing port. Each write must leave the pointer one past the written slot. Only the bench scenarios can show the byte-level behaviour: which value comes back for which pointer, that an input byte takes the pins at its own load edge rather than at the start of the burst, that each output lands before the next byte begins, that the pointer wraps, and that the target stays silent after a wrong address or a master not-acknowledge.

// File: rtl/i2cgp_pkg.sv
package i2cgp_pkg;

    localparam int PTR_W  = 4;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_st_e;

    typedef enum logic [1:0] {
        ROLE_DEV,
        ROLE_REG,
        ROLE_DATA
    } rx_role_e;

    // Line events seen in the system clock domain
    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic is_out_slot(logic [PTR_W-1:0] p);
        return p[PTR_W-1];
    endfunction

endpackage

// File: rtl/i2cgp_line_sync.sv
module i2cgp_line_sync
    import i2cgp_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_prev, sda_prev;
    logic              scl_s, sda_s;

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q    <= '1;
            sda_q    <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_q    <= {scl_q[STAGES-2:0], scl_i};
            sda_q    <= {sda_q[STAGES-2:0], sda_i};
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    always_comb begin
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_prev;
        ev.scl_fall = ~scl_s & scl_prev;
        ev.start    = scl_s & scl_prev & sda_prev & ~sda_s;
        ev.stop     = scl_s & scl_prev & ~sda_prev & sda_s;
    end

endmodule

// File: rtl/i2cgp_target_fsm.sv
module i2cgp_target_fsm
    import i2cgp_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  ptr,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output bus_st_e           state
);
    rx_role_e          role;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw, ack_ok, mack;
    logic              ack_drv, tx_drv;
    logic [BYTE_W-1:0] rx_byte;

    assign rx_byte = {shreg[BYTE_W-2:0], ev.sda};
    assign sda_oe  = ack_drv | (tx_drv & ~shreg[BYTE_W-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            role    <= ROLE_DEV;
            cnt     <= '0;
            shreg   <= '0;
            rw      <= 1'b0;
            ack_ok  <= 1'b0;
            mack    <= 1'b0;
            ack_drv <= 1'b0;
            tx_drv  <= 1'b0;
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (ev.stop) begin
                state   <= ST_IDLE;
                ack_drv <= 1'b0;
                tx_drv  <= 1'b0;
            end else if (ev.start) begin
                state   <= ST_RX;
                role    <= ROLE_DEV;
                cnt     <= '0;
                ack_drv <= 1'b0;
                tx_drv  <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (ev.scl_rise && cnt < 4'd8) begin
                            shreg <= rx_byte;
                            cnt   <= cnt + 4'd1;
                            if (cnt == 4'd7) begin
                                case (role)
                                    ROLE_DEV: begin
                                        ack_ok <= (rx_byte[7:1] == DEV_ADDR);
                                        rw     <= rx_byte[0];
                                    end
                                    ROLE_REG: begin
                                        ack_ok <= 1'b1;
                                        ptr    <= rx_byte[PTR_W-1:0];
                                    end
                                    default: begin
                                        ack_ok  <= 1'b1;
                                        wr_en   <= 1'b1;
                                        wr_addr <= ptr;
                                        wr_data <= rx_byte;
                                        ptr     <= ptr + 4'd1;
                                    end
                                endcase
                            end
                        end else if (ev.scl_fall && cnt == 4'd8) begin
                            if (ack_ok) begin
                                state   <= ST_RX_ACK;
                                ack_drv <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (ev.scl_fall) begin
                            ack_drv <= 1'b0;
                            cnt     <= '0;
                            if (role == ROLE_DEV && rw) begin
                                shreg  <= rd_data;
                                tx_drv <= 1'b1;
                                ptr    <= ptr + 4'd1;
                                state  <= ST_TX;
                            end else begin
                                state <= ST_RX;
                                role  <= (role == ROLE_DEV) ? ROLE_REG : ROLE_DATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (ev.scl_fall) begin
                            if (cnt == 4'd8) begin
                                tx_drv <= 1'b0;
                                state  <= ST_TX_ACK;
                            end else begin
                                shreg <= {shreg[BYTE_W-2:0], 1'b0};
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (ev.scl_rise) begin
                            mack <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (mack) begin
                                shreg  <= rd_data;
                                tx_drv <= 1'b1;
                                ptr    <= ptr + 4'd1;
                                cnt    <= '0;
                                state  <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2cgp_port_regs.sv
module i2cgp_port_regs
    import i2cgp_pkg::*;
#(
    parameter int NPORT = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NPORT-1:0][BYTE_W-1:0]  port_in,
    input  logic                          wr_en,
    input  logic [PTR_W-1:0]              wr_addr,
    input  logic [BYTE_W-1:0]             wr_data,
    input  logic [PTR_W-1:0]              rd_addr,
    output logic [BYTE_W-1:0]             rd_data,
    output logic [NPORT-1:0][BYTE_W-1:0]  port_out
);
    logic [NPORT-1:0][BYTE_W-1:0] out_q;

    for (genvar k = 0; k < NPORT; k++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst) begin
                out_q[k] <= '0;
            end else if (wr_en && wr_addr == {1'b1, 3'(k)}) begin
                out_q[k] <= wr_data;
            end
        end
    end

    // Live mux: an input slot reflects the pins in the cycle the FSM loads it
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NPORT; k++) begin
            if (rd_addr[2:0] == 3'(k)) begin
                rd_data = is_out_slot(rd_addr) ? out_q[k] : port_in[k];
            end
        end
    end

    assign port_out = out_q;

endmodule

// File: rtl/i2cgp_top.sv
module i2cgp_top
    import i2cgp_pkg::*;
#(
    parameter int         NPORT       = 4,
    parameter logic [6:0] DEV_ADDR    = 7'h20,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [NPORT*8-1:0] port_in,
    output logic [NPORT*8-1:0] port_out
);
    bus_ev_t                      ev;
    bus_st_e                      fsm_state;
    logic [PTR_W-1:0]             ptr;
    logic                         wr_en;
    logic [PTR_W-1:0]             wr_addr;
    logic [BYTE_W-1:0]            wr_data;
    logic [BYTE_W-1:0]            rd_data;
    logic [NPORT-1:0][BYTE_W-1:0] pin_arr, out_arr;

    assign pin_arr  = port_in;
    assign port_out = out_arr;

    i2cgp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2cgp_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .rd_data (rd_data),
        .sda_oe  (sda_oe),
        .ptr     (ptr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .state   (fsm_state)
    );

    i2cgp_port_regs #(.NPORT(NPORT)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .port_in  (pin_arr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (ptr),
        .rd_data  (rd_data),
        .port_out (out_arr)
    );

endmodule

// File: rtl/i2cgp_checker.sv
module i2cgp_checker
    import i2cgp_pkg::*;
#(
    parameter int NPORT = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               scl_i,
    input logic               sda_oe,
    input bus_st_e            fsm_state,
    input logic               wr_en,
    input logic [PTR_W-1:0]   wr_addr,
    input logic [PTR_W-1:0]   ptr,
    input logic [NPORT*8-1:0] port_out
);
    localparam logic [3:0] NP4 = 4'(NPORT);

    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (port_out == '0 && !sda_oe));

    p_sda_scl_low_r12: assert property (@(posedge clk) disable iff (rst)
        $changed(sda_oe) |-> !scl_i);

    p_out_on_write_r4: assert property (@(posedge clk) disable iff (rst)
        $changed(port_out) |-> $past(wr_en));

    p_ptr_step_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (ptr == wr_addr + 4'd1));

    p_input_write_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_addr[3]) |=> $stable(port_out));

    p_missing_port_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && {1'b0, wr_addr[2:0]} >= NP4) |=> $stable(port_out));

    p_idle_release_r10: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == ST_IDLE) |-> !sda_oe);

endmodule

bind i2cgp_top i2cgp_checker #(.NPORT(NPORT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .fsm_state (fsm_state),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .ptr       (ptr),
    .port_out  (port_out)
);

// File: tb/i2cgp_top_tb.sv
module i2cgp_top_tb;
    localparam int         NPORT = 4;
    localparam logic [6:0] DEV   = 7'h20;
    localparam int         Q     = 10;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               scl_drv = 1'b1;
    logic               sda_drv = 1'b1;
    logic               sda_oe;
    logic               sda_bus;
    logic [NPORT*8-1:0] port_in = '0;
    logic [NPORT*8-1:0] port_out;

    int checks = 0;
    int errors = 0;
    int r12_viol = 0;
    logic prev_oe = 1'b0;

    assign sda_bus = sda_drv & ~sda_oe;

    always #2.5 clk = ~clk;

    i2cgp_top #(.NPORT(NPORT), .DEV_ADDR(DEV)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl_drv),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .port_in  (port_in),
        .port_out (port_out)
    );

    // R12 monitor: drive must not change while the master holds SCL high
    always @(negedge clk) begin
        if (!rst && sda_oe !== prev_oe && scl_drv) r12_viol++;
        prev_oe = sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b0; qwait();
        scl_drv = 1'b0; qwait();
    endtask

    task automatic bus_rstart();
        sda_drv = 1'b1; qwait();
        scl_drv = 1'b1; qwait();
        sda_drv = 1'b0; qwait();
        scl_drv = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; qwait();
        scl_drv = 1'b1; qwait();
        sda_drv = 1'b1; qwait();
    endtask

    task automatic send_bit(input logic b, output logic s);
        sda_drv = b;    qwait();
        scl_drv = 1'b1; qwait();
        s = sda_bus;    qwait();
        scl_drv = 1'b0; qwait();
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) send_bit(b[i], s);
        send_bit(1'b1, ack);
    endtask

    task automatic read_bits(output logic [7:0] v);
        logic s;
        for (int i = 0; i < 8; i++) begin
            send_bit(1'b1, s);
            v = {v[6:0], s};
        end
    endtask

    task automatic open_write(input logic [7:0] regaddr);
        logic a;
        bus_start();
        write_byte({DEV, 1'b0}, a);
        chk("R2 address ack", 32'(a), 32'd0);
        write_byte(regaddr, a);
        chk("R3 register byte ack", 32'(a), 32'd0);
    endtask

    task automatic open_read(input logic [7:0] regaddr);
        logic a;
        open_write(regaddr);
        bus_rstart();
        write_byte({DEV, 1'b1}, a);
        chk("R11 read address ack", 32'(a), 32'd0);
    endtask

    function automatic logic [7:0] pout(input int k);
        return port_out[k*8 +: 8];
    endfunction

    task automatic t_reset();
        chk("R1 port_out after reset", port_out, 32'h0);
        chk("R1 sda_oe after reset", 32'(sda_oe), 32'd0);
    endtask

    task automatic t_wrong_addr();
        logic a;
        bus_start();
        write_byte({7'h21, 1'b0}, a);
        chk("R2 wrong address not acked", 32'(a), 32'd1);
        write_byte(8'h09, a);
        chk("R2 ignored register byte", 32'(a), 32'd1);
        write_byte(8'h55, a);
        chk("R2 ignored data byte", 32'(a), 32'd1);
        bus_stop();
        chk("R2 no write after wrong address", port_out, 32'h0);
    endtask

    task automatic t_write_burst();
        logic a;
        logic [7:0] v [1:3];
        v[1] = 8'hA1; v[2] = 8'hB2; v[3] = 8'hC3;
        open_write(8'h09);
        for (int k = 1; k <= 3; k++) begin
            write_byte(v[k], a);
            chk("R4 data ack", 32'(a), 32'd0);
            chk("R4 port updated before next byte", 32'(pout(k)), 32'(v[k]));
            if (k < 3) chk("R5 next port not yet written", 32'(pout(k+1)), 32'h0);
        end
        chk("R4 port 0 untouched", 32'(pout(0)), 32'h0);
        bus_stop();
    endtask

    task automatic t_readback();
        logic [7:0] d;
        logic s;
        logic [7:0] exp [0:3];
        exp[0] = 8'h00; exp[1] = 8'hA1; exp[2] = 8'hB2; exp[3] = 8'hC3;
        open_read(8'h08);
        for (int k = 0; k < 4; k++) begin
            read_bits(d);
            chk("R7 output readback", 32'(d), 32'(exp[k]));
            send_bit(k == 3, s);
        end
        for (int i = 0; i < 9; i++) begin
            send_bit(1'b1, s);
            chk("R10 SDA released after NACK", 32'(s), 32'd1);
        end
        bus_stop();
    endtask

    task automatic t_read_inputs();
        logic [7:0] d;
        logic s;
        port_in = {8'h44, 8'h00, 8'h11, 8'h99};
        open_read(8'h01);
        read_bits(d);
        chk("R6 port 1 captured at its load edge", 32'(d), 32'h11);
        port_in[15:8]  = 8'hEE;
        port_in[23:16] = 8'h3C;
        send_bit(1'b0, s);
        read_bits(d);
        chk("R6 port 2 sampled when its byte starts", 32'(d), 32'h3C);
        send_bit(1'b1, s);
        bus_stop();
    endtask

    task automatic t_input_write_ignored();
        logic a;
        logic [7:0] d;
        logic s;
        logic [NPORT*8-1:0] snap;
        snap = port_out;
        open_write(8'h02);
        write_byte(8'hFF, a);
        chk("R8 input-slot write acked", 32'(a), 32'd0);
        write_byte(8'h5A, a);
        chk("R8 second input-slot write acked", 32'(a), 32'd0);
        bus_stop();
        chk("R8 outputs unchanged", port_out, snap);
        open_read(8'h02);
        read_bits(d);
        chk("R8 input slot still reads pins", 32'(d), 32'h3C);
        send_bit(1'b1, s);
        bus_stop();
    endtask

    task automatic t_missing_port();
        logic a;
        logic [7:0] d;
        logic s;
        logic [NPORT*8-1:0] snap;
        snap = port_out;
        open_write(8'h0E);
        write_byte(8'h77, a);
        chk("R9 missing-port write acked", 32'(a), 32'd0);
        bus_stop();
        chk("R9 missing-port write ignored", port_out, snap);
        open_read(8'h06);
        read_bits(d);
        chk("R9 missing input port 6 reads zero", 32'(d), 32'h0);
        send_bit(1'b0, s);
        read_bits(d);
        chk("R9 missing input port 7 reads zero", 32'(d), 32'h0);
        send_bit(1'b1, s);
        bus_stop();
        open_read(8'h0E);
        read_bits(d);
        chk("R9 missing output port reads zero", 32'(d), 32'h0);
        send_bit(1'b1, s);
        bus_stop();
    endtask

    task automatic t_upper_nibble();
        logic a;
        open_write(8'h19);
        write_byte(8'h66, a);
        chk("R3 upper nibble ignored, port 1 written", 32'(pout(1)), 32'h66);
        bus_stop();
    endtask

    task automatic t_wrap();
        logic [7:0] d;
        logic s;
        open_read(8'h0F);
        read_bits(d);
        chk("R5 slot Fh reads zero", 32'(d), 32'h0);
        send_bit(1'b0, s);
        read_bits(d);
        chk("R5 pointer wraps to input port 0", 32'(d), 32'h99);
        send_bit(1'b1, s);
        bus_stop();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_wrong_addr();
        t_write_burst();
        t_readback();
        t_read_inputs();
        t_input_write_ignored();
        t_missing_port();
        t_upper_nibble();
        t_wrap();
        chk("R12 SDA drive changes only with SCL low", r12_viol, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule